// File: doc/BRIEF.md
# DRAM Refresh Mode Decoder

This block sits on the device side of an asynchronous-strobe DRAM and watches the row strobe, column strobe and write strobe once per clock. Each period in which the row strobe is low is classified from the order in which the strobes fell. The period can be an ordinary access, a refresh that uses the row address on the pins, a refresh that takes its row from an internal counter (column strobe first), a hidden refresh that follows a read with the column strobe still low, or an entry into self-refresh. All strobes are active low.

The block keeps an internal refresh row counter that persists across all modes. Each refresh it performs comes out as a one-cycle strobe together with the row to refresh. In self-refresh an internal tick divider issues refreshes on its own until both strobes are seen high again. All outputs are registered. Each row-strobe low period produces one classification pulse on the clock edge where the row strobe is first sampled high again.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: `cyc_valid_o` pulses for one cycle, after the edge where `ras_n_i` is first sampled high following a low period. `cyc_type_o` then carries the class, encoded 0 access, 1 external-row refresh, 2 counter refresh, 3 hidden refresh, 4 self-refresh exit, 5 rejected. Class 0 means `cas_n_i` was high at the row-strobe fall and fell later within the period. An access raises no refresh strobe.
- R2: If `cas_n_i` stays high for the whole low period, the class is 1. `ref_stb_o` pulses with `ref_row_o` equal to `row_addr_i` as sampled at the row-strobe fall, and `dq_hold_o` stays low.
- R3: If `cas_n_i` is sampled low both on the edge before the row-strobe fall and on the fall edge itself, and `we_n_i` is high at the fall, the class is 2. The refresh row is the counter value, and `row_addr_i` has no effect.
- R4: With `cas_n_i` kept low, every further row-strobe low period is a class 2 refresh, and consecutive periods refresh consecutive rows.
- R5: The refresh row counter is ROW_W bits wide (default 11, 2048 rows) and is zero after reset. It advances by one after each refresh that it supplies, and it wraps from 2047 to 0.
- R6: An access in which `we_n_i` was high when `cas_n_i` fell, and which ends with `cas_n_i` still low, raises `dq_hold_o`. `dq_hold_o` stays high until `cas_n_i` is sampled high. A row-strobe low period that starts while `dq_hold_o` is high is class 3 and uses the counter row.
- R7: In a column-strobe-first period with `we_n_i` low at the fall, the class is 5. No refresh strobe is raised and the counter is unchanged.
- R8: When a class 2 period has both strobes sampled low on SREF_ENTRY_TICKS consecutive edges after the fall, `self_ref_o` rises on that edge and one counter refresh is issued. A shorter period stays class 2.
- R9: While `self_ref_o` is high, a counter refresh is issued every SREF_PERIOD_TICKS edges.
- R10: Self-refresh ends only on an edge where both `ras_n_i` and `cas_n_i` are sampled high. `self_ref_o` then falls and class 4 is reported without a refresh strobe. The row strobe going high on its own does not end self-refresh.
- R11: If both strobes are first sampled low on the same edge, the period is treated as starting with the row strobe, and ends as class 0 or 1.
- R12: During reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| row_addr_i | input | ROW_W | Row address from the pins |
| cyc_valid_o | output | 1 | Classification pulse |
| cyc_type_o | output | 3 | Class of the ended period |
| ref_stb_o | output | 1 | Refresh strobe |
| ref_row_o | output | ROW_W | Row to refresh |
| self_ref_o | output | 1 | Self-refresh active |
| dq_hold_o | output | 1 | Read data kept driven |

## Verification
The hardest state to reach is the counter wrap. It needs 2048 counter refreshes, so the stimulus keeps the column strobe low and pulses the row strobe for one clock at a time, giving a successive refresh every two cycles. Self-refresh is reached with shortened entry and period tick counts. The stimulus then holds only the row strobe high for a few cycles before releasing both strobes. Hidden refresh needs a read that ends with the column strobe still low, followed by a new row-strobe pulse.

// File: rtl/drf_pkg.sv
package drf_pkg;
  typedef enum logic [2:0] {
    CYC_ACCESS   = 3'd0,
    CYC_RAS_ONLY = 3'd1,
    CYC_CBR      = 3'd2,
    CYC_HIDDEN   = 3'd3,
    CYC_SELF     = 3'd4,
    CYC_REJECT   = 3'd5
  } cyc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_EXT,
    PH_CBR,
    PH_HID,
    PH_BAD,
    PH_SELF
  } phase_e;
endpackage

// File: rtl/drf_strobe_sync.sv
module drf_strobe_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_n_i,
  input  logic cas_n_i,
  output logic ras_fall_o,
  output logic ras_rise_o,
  output logic cas_was_low_o
);
  logic ras_q, cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      ras_q <= ras_n_i;
      cas_q <= cas_n_i;
    end
  end

  assign ras_fall_o    = ras_q & ~ras_n_i;
  assign ras_rise_o    = ~ras_q & ras_n_i;
  assign cas_was_low_o = ~cas_q;
endmodule

// File: rtl/drf_row_ctr.sv
module drf_row_ctr #(
  parameter int ROW_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  // natural modulo-2^ROW_W wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (inc_i) row_o <= row_o + 1'b1;
  end
endmodule

// File: rtl/drf_tick_timer.sv
module drf_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (hit_o)  cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import drf_pkg::*;
#(
  parameter int ROW_W             = 11,
  parameter int SREF_ENTRY_TICKS  = 20000,
  parameter int SREF_PERIOD_TICKS = 3125
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_n_i,
  input  logic             cas_n_i,
  input  logic             we_n_i,
  input  logic [ROW_W-1:0] row_addr_i,
  output logic             cyc_valid_o,
  output logic [2:0]       cyc_type_o,
  output logic             ref_stb_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             self_ref_o,
  output logic             dq_hold_o
);
  phase_e           phase_q, phase_d;
  logic             seen_q, seen_d, read_q, read_d;
  logic [ROW_W-1:0] row_q, row_d, stb_row_d, ctr_row;
  logic             held_d, valid_d, stb_d, self_d, ctr_inc;
  cyc_kind_e        type_d;
  logic             ras_fall, ras_rise, cas_was_low;
  logic             entry_run, entry_hit, per_run, per_hit;
  logic             seen_eff, read_eff;

  drf_strobe_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i),
    .ras_fall_o(ras_fall), .ras_rise_o(ras_rise), .cas_was_low_o(cas_was_low)
  );

  drf_row_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(ctr_inc), .row_o(ctr_row)
  );

  assign entry_run = (phase_q == PH_CBR) && !ras_n_i && !cas_n_i;
  assign per_run   = (phase_q == PH_SELF) && !(ras_n_i && cas_n_i);

  drf_tick_timer #(.LIMIT(SREF_ENTRY_TICKS)) u_entry (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(entry_run), .hit_o(entry_hit)
  );

  drf_tick_timer #(.LIMIT(SREF_PERIOD_TICKS)) u_period (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(per_run), .hit_o(per_hit)
  );

  // column strobe may fall on the same edge the row strobe rises
  assign seen_eff = seen_q | ~cas_n_i;
  assign read_eff = seen_q ? read_q : we_n_i;

  always_comb begin
    phase_d   = phase_q;
    seen_d    = seen_q;
    read_d    = read_q;
    row_d     = row_q;
    held_d    = cas_n_i ? 1'b0 : dq_hold_o;
    valid_d   = 1'b0;
    type_d    = CYC_ACCESS;
    stb_d     = 1'b0;
    stb_row_d = ctr_row;
    self_d    = self_ref_o;
    ctr_inc   = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (ras_fall) begin
        if (cas_was_low && !cas_n_i) begin
          if (dq_hold_o)     phase_d = PH_HID;
          else if (!we_n_i)  phase_d = PH_BAD;
          else               phase_d = PH_CBR;
        end else begin
          phase_d = PH_EXT;
          row_d   = row_addr_i;
          seen_d  = !cas_n_i;
          read_d  = we_n_i;
        end
      end
      PH_EXT: if (ras_rise) begin
        valid_d = 1'b1;
        phase_d = PH_IDLE;
        held_d  = seen_eff && read_eff && !cas_n_i;
        if (seen_eff) type_d = CYC_ACCESS;
        else begin
          type_d    = CYC_RAS_ONLY;
          stb_d     = 1'b1;
          stb_row_d = row_q;
        end
      end else if (!cas_n_i && !seen_q) begin
        seen_d = 1'b1;
        read_d = we_n_i;
      end
      PH_CBR: if (ras_rise) begin
        valid_d = 1'b1;
        type_d  = CYC_CBR;
        stb_d   = 1'b1;
        ctr_inc = 1'b1;
        phase_d = PH_IDLE;
      end else if (entry_hit) begin
        phase_d = PH_SELF;
        self_d  = 1'b1;
        stb_d   = 1'b1;
        ctr_inc = 1'b1;
      end
      PH_HID: if (ras_rise) begin
        valid_d = 1'b1;
        type_d  = CYC_HIDDEN;
        stb_d   = 1'b1;
        ctr_inc = 1'b1;
        phase_d = PH_IDLE;
      end
      PH_BAD: if (ras_rise) begin
        valid_d = 1'b1;
        type_d  = CYC_REJECT;
        phase_d = PH_IDLE;
      end
      PH_SELF: if (ras_n_i && cas_n_i) begin
        valid_d = 1'b1;
        type_d  = CYC_SELF;
        self_d  = 1'b0;
        phase_d = PH_IDLE;
      end else if (per_hit) begin
        stb_d   = 1'b1;
        ctr_inc = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      seen_q      <= 1'b0;
      read_q      <= 1'b0;
      row_q       <= '0;
      dq_hold_o   <= 1'b0;
      cyc_valid_o <= 1'b0;
      cyc_type_o  <= 3'd0;
      ref_stb_o   <= 1'b0;
      ref_row_o   <= '0;
      self_ref_o  <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      seen_q      <= seen_d;
      read_q      <= read_d;
      row_q       <= row_d;
      dq_hold_o   <= held_d;
      cyc_valid_o <= valid_d;
      cyc_type_o  <= valid_d ? type_d : 3'd0;
      ref_stb_o   <= stb_d;
      self_ref_o  <= self_d;
      if (stb_d) ref_row_o <= stb_row_d;
    end
  end
endmodule

// File: rtl/drf_checks.sv
module drf_checks #(
  parameter int ROW_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_valid_o,
  input logic [2:0]       cyc_type_o,
  input logic             ref_stb_o,
  input logic [ROW_W-1:0] ref_row_o,
  input logic             self_ref_o,
  input logic             dq_hold_o
);
  logic             internal_stb;
  logic             have_prev;
  logic [ROW_W-1:0] prev_row;

  assign internal_stb = ref_stb_o && !(cyc_valid_o && cyc_type_o == 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev <= 1'b0;
      prev_row  <= '0;
    end else if (internal_stb) begin
      have_prev <= 1'b1;
      prev_row  <= ref_row_o;
    end
  end

  // R5: counter rows advance by one between internal refreshes
  a_r5_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    internal_stb && have_prev |-> ref_row_o == ROW_W'(prev_row + 1'b1));

  // R2 R3: refresh classes carry a strobe, access does not
  a_r3_stb_with_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && (cyc_type_o inside {3'd1, 3'd2, 3'd3}) |-> ref_stb_o);

  a_r1_access_no_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_type_o == 3'd0 |-> !ref_stb_o);

  a_r7_reject_no_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_type_o == 3'd5 |-> !ref_stb_o);

  a_r10_exit_reported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(self_ref_o) |-> cyc_valid_o && cyc_type_o == 3'd4 && !ref_stb_o);

  a_r6_hold_not_in_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_hold_o |-> !self_ref_o);

  a_r1_type_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |-> cyc_type_o <= 3'd5);
endmodule

bind dram_refresh_ctrl drf_checks #(.ROW_W(ROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_valid_o(cyc_valid_o),
  .cyc_type_o(cyc_type_o), .ref_stb_o(ref_stb_o), .ref_row_o(ref_row_o),
  .self_ref_o(self_ref_o), .dq_hold_o(dq_hold_o)
);

// File: tb/sim_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctrl;
  localparam int ROW_W = 11;
  localparam int ENTRY = 40;
  localparam int PER   = 12;
  localparam int NROWS = 1 << ROW_W;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ras = 1'b1, cas = 1'b1, we = 1'b1;
  logic [ROW_W-1:0] row_i = '0;
  logic cyc_valid, ref_stb, self_ref, dq_hold;
  logic [2:0] cyc_type;
  logic [ROW_W-1:0] ref_row;

  int errors = 0, checks = 0, exp_ctr = 0;

  always #2.5 clk = ~clk;

  dram_refresh_ctrl #(.ROW_W(ROW_W), .SREF_ENTRY_TICKS(ENTRY), .SREF_PERIOD_TICKS(PER)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ras_n_i(ras), .cas_n_i(cas), .we_n_i(we),
    .row_addr_i(row_i), .cyc_valid_o(cyc_valid), .cyc_type_o(cyc_type),
    .ref_stb_o(ref_stb), .ref_row_o(ref_row), .self_ref_o(self_ref), .dq_hold_o(dq_hold)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ph, m_rq, m_cq, m_seen, m_read, m_row, m_held, m_ctr, m_low, m_per;
  int m_valid, m_type, m_stb, m_rowo, m_self;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_rq = 1; m_cq = 1; m_seen = 0; m_read = 0; m_row = 0; m_held = 0;
      m_ctr = 0; m_low = 0; m_per = 0; m_valid = 0; m_type = 0; m_stb = 0; m_rowo = 0; m_self = 0;
    end else begin
      int r, c, w, ext_rise;
      r = ras; c = cas; w = we; ext_rise = 0;
      m_valid = 0; m_stb = 0; m_type = 0;
      case (m_ph)
        0: if (m_rq && !r) begin
             if (!m_cq && !c) begin
               m_ph = m_held ? 3 : (!w ? 4 : 2);
               m_low = 0;
             end else begin
               m_ph = 1; m_row = row_i; m_seen = !c; m_read = w;
             end
           end
        1: if (r) begin
             int se, rd;
             se = m_seen || !c;
             rd = m_seen ? m_read : w;
             m_valid = 1; ext_rise = 1;
             if (se) m_type = 0;
             else begin m_type = 1; m_stb = 1; m_rowo = m_row; end
             m_held = se && rd && !c;
             m_ph = 0;
           end else if (!c && !m_seen) begin
             m_seen = 1; m_read = w;
           end
        2: if (r) begin
             m_valid = 1; m_type = 2; m_stb = 1; m_rowo = m_ctr;
             m_ctr = (m_ctr + 1) % NROWS; m_ph = 0;
           end else if (!c) begin
             m_low++;
             if (m_low == ENTRY) begin
               m_ph = 5; m_self = 1; m_stb = 1; m_rowo = m_ctr;
               m_ctr = (m_ctr + 1) % NROWS; m_per = 0;
             end
           end else m_low = 0;
        3: if (r) begin
             m_valid = 1; m_type = 3; m_stb = 1; m_rowo = m_ctr;
             m_ctr = (m_ctr + 1) % NROWS; m_ph = 0;
           end
        4: if (r) begin m_valid = 1; m_type = 5; m_ph = 0; end
        default: if (r && c) begin
             m_valid = 1; m_type = 4; m_self = 0; m_ph = 0; m_per = 0;
           end else begin
             m_per++;
             if (m_per == PER) begin
               m_stb = 1; m_rowo = m_ctr; m_ctr = (m_ctr + 1) % NROWS; m_per = 0;
             end
           end
      endcase
      if (!ext_rise && c) m_held = 0;
      m_rq = r; m_cq = c;
    end
  end

  logic done = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 model valid", cyc_valid, m_valid);
      chk("R1 model type", cyc_type, m_type);
      chk("R3 model strobe", ref_stb, m_stb);
      chk("R5 model row", ref_row, m_rowo);
      chk("R8 model self", self_ref, m_self);
      chk("R6 model hold", dq_hold, m_held);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  task automatic nxt(); @(negedge clk); endtask

  task automatic end_period(input string tag, input int typ, input int stb, input int row);
    ras = 1'b1;
    nxt();
    chk({tag, " valid"}, cyc_valid, 1);
    chk({tag, " type"}, cyc_type, typ);
    chk({tag, " strobe"}, ref_stb, stb);
    if (stb) chk({tag, " row"}, ref_row, row);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    nxt(); nxt();
    // R12: reset state
    chk("R12 valid", cyc_valid, 0); chk("R12 stb", ref_stb, 0);
    chk("R12 self", self_ref, 0); chk("R12 hold", dq_hold, 0);
    chk("R12 row", ref_row, 0);
    rst_n = 1'b1;
    nxt();

    // R2: external-row refresh
    ras = 0; row_i = 11'h155; nxt(); row_i = 11'h0AA; nxt(); nxt();
    end_period("R2 ras-only", 1, 1, 'h155);
    chk("R2 hold", dq_hold, 0);
    nxt();

    // R1: plain write access
    ras = 0; row_i = 11'h321; nxt(); cas = 0; we = 0; nxt(); nxt();
    end_period("R1 access", 0, 0, 0);
    cas = 1; we = 1; nxt();

    // R3: counter refresh, pin address ignored
    cas = 0; nxt(); ras = 0; row_i = 11'h7FF; nxt(); nxt(); nxt();
    end_period("R3 cbr", 2, 1, exp_ctr); exp_ctr++;
    cas = 1; nxt();

    // R7: write strobe low during column-first period
    cas = 0; nxt(); ras = 0; we = 0; nxt(); nxt();
    end_period("R7 reject", 5, 0, 0);
    we = 1; cas = 1; nxt();
    cas = 0; nxt(); ras = 0; nxt();
    end_period("R7 counter kept", 2, 1, exp_ctr); exp_ctr++;
    cas = 1; nxt();

    // R11: both strobes fall together
    ras = 0; cas = 0; nxt(); nxt();
    end_period("R11 same edge", 0, 0, 0);
    cas = 1; nxt();

    // R6: read held open, then hidden refresh
    ras = 0; row_i = 11'h042; nxt(); cas = 0; we = 1; nxt(); nxt();
    end_period("R6 read", 0, 0, 0);
    chk("R6 hold after read", dq_hold, 1);
    ras = 0; nxt(); nxt();
    end_period("R6 hidden", 3, 1, exp_ctr); exp_ctr++;
    chk("R6 hold during hidden", dq_hold, 1);
    cas = 1; nxt();
    chk("R6 hold released", dq_hold, 0);

    // R4: successive counter refreshes with column strobe held low
    cas = 0; nxt();
    for (int i = 0; i < 3; i++) begin
      ras = 0; nxt();
      end_period("R4 successive", 2, 1, exp_ctr); exp_ctr++;
    end
    cas = 1; nxt();

    // R8: long but below threshold
    cas = 0; nxt(); ras = 0;
    repeat (ENTRY - 2) nxt();
    chk("R8 no early self", self_ref, 0);
    end_period("R8 short stays cbr", 2, 1, exp_ctr); exp_ctr++;
    cas = 1; nxt();

    // R8 R9 R10: self-refresh
    cas = 0; nxt(); ras = 0;
    repeat (ENTRY + 1) nxt();
    chk("R8 self entered", self_ref, 1);
    chk("R8 entry strobe", ref_stb, 1);
    chk("R8 entry row", ref_row, exp_ctr % NROWS); exp_ctr++;
    repeat (3 * PER) nxt();
    chk("R9 periodic strobe", ref_stb, 1);
    chk("R9 periodic row", ref_row, (exp_ctr + 2) % NROWS); exp_ctr += 3;
    ras = 1; repeat (4) nxt();
    chk("R10 ras alone keeps self", self_ref, 1);
    cas = 1; nxt();
    chk("R10 self exit", self_ref, 0);
    chk("R10 exit class", cyc_type, 4);
    chk("R10 exit valid", cyc_valid, 1);
    chk("R10 exit no strobe", ref_stb, 0);
    nxt();

    // R5: run the counter through its wrap
    cas = 0; nxt();
    while (exp_ctr <= NROWS) begin
      ras = 0; nxt();
      end_period((exp_ctr % NROWS == 0) ? "R5 wrap" : "R4 run", 2, 1, exp_ctr % NROWS);
      exp_ctr++;
    end
    cas = 1; nxt(); nxt();
    finish_run();
  end
endmodule